// File: doc/BRIEF.md
# Field-Oriented Current Control Step

This block carries out one complete current-loop update of a field-oriented motor controller each time it is started. A single start pulse takes a snapshot of two phase-current samples, the rotor angle, the direct- and quadrature-axis current setpoints, the four regulator gains and a voltage limit. The block then turns the phase currents into a stationary two-axis vector and rotates that vector into the rotor frame. It regulates the direct and quadrature components side by side, each with its own proportional-integral loop. It rotates the two resulting voltage commands back into the stationary frame, where a space-vector modulator can use them.

Sine and cosine of the rotor angle come from an iterative shift-and-add rotation that runs while the stationary-frame currents are being formed. The result is ready a fixed number of clock cycles after start, far inside a 100 µs modulation period. A one-cycle done pulse marks the result, and the voltage outputs keep their values until the next result.

Top module: `foc_current_step`

## Requirements
- R1: An accepted start is the rising clock edge where start_i is high and the block is idle. done_o is high for exactly one cycle, directly after the edge ITER+4 edges later (18 with defaults). It is low at every other time.
- R2: The stationary frame is alpha = ia and beta = (ia + 2·ib)/√3. The division uses a constant multiply by 1/√3. Currents are signed Q1.15.
- R3: The rotor angle is a signed 16-bit value, with 65536 counts per turn and 0 on the alpha axis. The block uses id = alpha·cos + beta·sin and iq = −alpha·sin + beta·cos, and this holds in all four quadrants.
- R4: Each axis has its own regulator. Error = reference − measured, output = kp·error + integral, and integral ← integral + ki·error. Gains are signed Q8.8, so 256 means 1.0.
- R5: Each integrator saturates at ±limit in output units (anti-windup). After a long period in saturation, a reversed error moves the output off the limit at the very next step.
- R6: The d/q regulator outputs and both alpha/beta outputs are clamped to ±vlim_i. vlim_i is non-negative.
- R7: The outputs are valpha = vd·cos − vq·sin and vbeta = vd·sin + vq·cos, in Q1.15.
- R8: valpha_o and vbeta_o change only in the cycle in which done_o is high. At all other times they hold their values.
- R9: After reset, done_o is low, both outputs are zero and both integrators are empty.
- R10: A start pulse that arrives while a step is in progress is ignored. It produces no extra done pulse and does not alter the result.
- R11: All inputs are sampled on the accepted start edge. Changing them later in the step has no effect on the result.
- R12: The d and q paths are independent. Zero q-axis gains leave the q integrator unchanged and do not change the d-axis result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one control step |
| ia_i | input | W | Phase A current, Q1.15 |
| ib_i | input | W | Phase B current, Q1.15 |
| theta_i | input | W | Rotor angle, signed, 2^W counts per turn |
| id_ref_i | input | W | Direct-axis current setpoint |
| iq_ref_i | input | W | Quadrature-axis current setpoint |
| kp_d_i | input | GAIN_W | d-axis proportional gain, Q8.8 |
| ki_d_i | input | GAIN_W | d-axis integral gain, Q8.8 |
| kp_q_i | input | GAIN_W | q-axis proportional gain, Q8.8 |
| ki_q_i | input | GAIN_W | q-axis integral gain, Q8.8 |
| vlim_i | input | W | Symmetric voltage and integrator limit, non-negative |
| done_o | output | 1 | One-cycle result strobe |
| valpha_o | output | W | Alpha voltage command |
| vbeta_o | output | W | Beta voltage command |

## Verification
The assertions assume the following about the inputs:
- vlim_i is non-negative and ACC_W is at least GAIN_W+W, so the regulator sums cannot wrap.
- The unit-magnitude check on the sine/cosine pair holds only with an iteration count near the default.

The stimulus follows these assumptions:
- It uses only positive limits, and it lowers the limit only between steps.
- It keeps gains within a few units.
- It raises start for a single cycle, except in the deliberate busy-start case.
- In the busy-start case, the extra start pulse and the input changes all fall strictly inside the step window.

// File: rtl/foc_pkg.sv
package foc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLARKE,
        ST_ROTATE,
        ST_PARK,
        ST_REG,
        ST_INV
    } step_state_e;

endpackage

// File: rtl/foc_sincos.sv
module foc_sincos #(
    parameter int W     = 16,
    parameter int ITER  = 14,
    parameter int GUARD = 4,
    parameter int ZEXT  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [W-1:0]        angle_i,
    output logic signed [W-1:0] sin_o,
    output logic signed [W-1:0] cos_o,
    output logic                valid_o
);
    localparam int XW = W + GUARD + 2;
    localparam int FR = W - 1 + GUARD;
    localparam int ZW = W + ZEXT + 2;
    localparam int TB = W + ZEXT;
    localparam int CW = $clog2(ITER + 1);
    localparam logic signed [XW-1:0] X_INIT = XW'(int'(0.6072529350 * (2.0 ** FR)));
    localparam logic signed [XW-1:0] RND    = XW'(2 ** (GUARD - 1));
    localparam logic signed [XW-1:0] OUT_HI = XW'(2 ** (W - 1) - 1);

    typedef struct packed {
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
        logic [CW-1:0]        it;
        logic                 busy;
        logic                 valid;
        logic                 flip;
    } rot_s;

    rot_s r_d, r_q;

    // arctangent of 2^-i, scaled to 2^32 counts per turn
    function automatic logic signed [ZW-1:0] step_angle(input logic [CW-1:0] i);
        longint t;
        case (int'(i))
            0:  t = 64'd536870912;
            1:  t = 64'd316933376;
            2:  t = 64'd167458816;
            3:  t = 64'd85004800;
            4:  t = 64'd42667264;
            5:  t = 64'd21354496;
            6:  t = 64'd10679808;
            7:  t = 64'd5340160;
            8:  t = 64'd2670080;
            9:  t = 64'd1335040;
            10: t = 64'd667648;
            11: t = 64'd333824;
            12: t = 64'd166912;
            13: t = 64'd83456;
            14: t = 64'd41728;
            15: t = 64'd20736;
            default: t = 64'd0;
        endcase
        return ZW'(t >>> (32 - TB));
    endfunction

    logic                 flip_in;
    logic signed [W-1:0]  folded;
    logic signed [XW-1:0] xs, ys, xr, yr;
    logic signed [ZW-1:0] ang;

    always_comb begin
        r_d     = r_q;
        flip_in = angle_i[W-1] ^ angle_i[W-2];
        folded  = flip_in ? $signed({~angle_i[W-1], angle_i[W-2:0]}) : $signed(angle_i);
        xs      = $signed(r_q.x) >>> r_q.it;
        ys      = $signed(r_q.y) >>> r_q.it;
        ang     = step_angle(r_q.it);
        if (start_i) begin
            r_d.x     = X_INIT;
            r_d.y     = '0;
            r_d.z     = ZW'(folded) <<< ZEXT;
            r_d.it    = '0;
            r_d.busy  = 1'b1;
            r_d.valid = 1'b0;
            r_d.flip  = flip_in;
        end else if (r_q.busy) begin
            if (!r_q.z[ZW-1]) begin
                r_d.x = $signed(r_q.x) - ys;
                r_d.y = $signed(r_q.y) + xs;
                r_d.z = $signed(r_q.z) - ang;
            end else begin
                r_d.x = $signed(r_q.x) + ys;
                r_d.y = $signed(r_q.y) - xs;
                r_d.z = $signed(r_q.z) + ang;
            end
            r_d.it = r_q.it + 1'b1;
            if (r_q.it == CW'(ITER - 1)) begin
                r_d.busy  = 1'b0;
                r_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        xr = ($signed(r_q.x) + RND) >>> GUARD;
        yr = ($signed(r_q.y) + RND) >>> GUARD;
        if (r_q.flip) begin
            xr = -xr;
            yr = -yr;
        end
        if (xr > OUT_HI)       xr = OUT_HI;
        else if (xr < -OUT_HI) xr = -OUT_HI;
        if (yr > OUT_HI)       yr = OUT_HI;
        else if (yr < -OUT_HI) yr = -OUT_HI;
        cos_o   = W'(xr);
        sin_o   = W'(yr);
        valid_o = r_q.valid;
    end

    logic signed [2*W+1:0] mag2;
    assign mag2 = sin_o * sin_o + cos_o * cos_o;

    // R1: the iteration index never runs past the last step
    p_iter_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.it < CW'(ITER)));

    // R3: a finished sine/cosine pair lies on the unit circle within 0.1 %
    p_trig_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (mag2 > (2*W+2)'((2.0 ** (2*W-2)) * 0.999)) &&
                    (mag2 < (2*W+2)'((2.0 ** (2*W-2)) * 1.001)));

endmodule

// File: rtl/foc_pi_axis.sv
module foc_pi_axis #(
    parameter int W         = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int ACC_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic signed [W-1:0]      ref_i,
    input  logic signed [W-1:0]      meas_i,
    input  logic signed [GAIN_W-1:0] kp_i,
    input  logic signed [GAIN_W-1:0] ki_i,
    input  logic signed [W-1:0]      lim_i,
    output logic signed [W-1:0]      v_o
);
    localparam int PW = GAIN_W + W + 1;
    localparam int SW = ACC_W + 2;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [W-1:0]     v;
    } pi_s;

    pi_s r_d, r_q;

    logic signed [W:0]    err;
    logic signed [PW-1:0] p_term, i_term;
    logic signed [SW-1:0] lim_acc, lim_v, acc_sum, acc_new, v_sum, v_new;

    always_comb begin
        r_d     = r_q;
        err     = $signed({ref_i[W-1], ref_i}) - $signed({meas_i[W-1], meas_i});
        p_term  = kp_i * err;
        i_term  = ki_i * err;
        lim_v   = SW'(lim_i);
        lim_acc = lim_v <<< GAIN_FRAC;
        acc_sum = SW'($signed(r_q.acc)) + SW'(i_term);
        if (acc_sum > lim_acc)       acc_new = lim_acc;
        else if (acc_sum < -lim_acc) acc_new = -lim_acc;
        else                         acc_new = acc_sum;
        v_sum = SW'(p_term) + acc_new;
        v_new = v_sum >>> GAIN_FRAC;
        if (v_new > lim_v)       v_new = lim_v;
        else if (v_new < -lim_v) v_new = -lim_v;
        if (en_i) begin
            r_d.acc = ACC_W'(acc_new);
            r_d.v   = W'(v_new);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign v_o = r_q.v;

    // R5: integrator never leaves the window given by the limit in force
    p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (SW'($signed(r_q.acc)) <= $past(lim_acc)) &&
                 (SW'($signed(r_q.acc)) >= -$past(lim_acc)));

    // R6: regulator output stays within the symmetric limit
    p_pi_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (SW'(v_o) <= $past(lim_v)) && (SW'(v_o) >= -$past(lim_v)));

endmodule

// File: rtl/foc_current_step.sv
module foc_current_step
    import foc_pkg::*;
#(
    parameter int W         = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int ACC_W     = 32,
    parameter int ITER      = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic signed [W-1:0]      ia_i,
    input  logic signed [W-1:0]      ib_i,
    input  logic [W-1:0]             theta_i,
    input  logic signed [W-1:0]      id_ref_i,
    input  logic signed [W-1:0]      iq_ref_i,
    input  logic signed [GAIN_W-1:0] kp_d_i,
    input  logic signed [GAIN_W-1:0] ki_d_i,
    input  logic signed [GAIN_W-1:0] kp_q_i,
    input  logic signed [GAIN_W-1:0] ki_q_i,
    input  logic signed [W-1:0]      vlim_i,
    output logic                     done_o,
    output logic signed [W-1:0]      valpha_o,
    output logic signed [W-1:0]      vbeta_o
);
    localparam int LAT = ITER + 4;
    localparam int PW  = 2 * W + 3;
    localparam int AW  = $clog2(LAT + 2);
    localparam logic signed [W:0]    INV_SQRT3 = (W+1)'(int'(0.5773502692 * (2.0 ** (W - 1))));
    localparam logic signed [PW-1:0] SAT_HI    = PW'(2 ** (W - 1) - 1);
    localparam logic signed [PW-1:0] SAT_LO    = -SAT_HI - 1;

    typedef struct packed {
        step_state_e             st;
        logic signed [W-1:0]     ia;
        logic signed [W-1:0]     ib;
        logic signed [W-1:0]     idr;
        logic signed [W-1:0]     iqr;
        logic signed [GAIN_W-1:0] kpd;
        logic signed [GAIN_W-1:0] kid;
        logic signed [GAIN_W-1:0] kpq;
        logic signed [GAIN_W-1:0] kiq;
        logic signed [W-1:0]     lim;
        logic signed [W-1:0]     alpha;
        logic signed [W-1:0]     beta;
        logic signed [W-1:0]     id;
        logic signed [W-1:0]     iq;
        logic signed [W-1:0]     va;
        logic signed [W-1:0]     vb;
        logic                    done;
    } step_s;

    step_s r_d, r_q;

    function automatic logic signed [W-1:0] sat_w(input logic signed [PW-1:0] v);
        if (v > SAT_HI)      return W'(SAT_HI);
        else if (v < SAT_LO) return W'(SAT_LO);
        else                 return W'(v);
    endfunction

    function automatic logic signed [W-1:0] clamp_lim(input logic signed [W-1:0] v,
                                                      input logic signed [W-1:0] lim);
        if (v > lim)       return lim;
        else if (v < -lim) return -lim;
        else               return v;
    endfunction

    // shared trig unit, started on the accepting edge
    logic                trig_go, trig_valid;
    logic signed [W-1:0] sin_w, cos_w;

    foc_sincos #(.W(W), .ITER(ITER), .GUARD(4), .ZEXT(8)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (trig_go),
        .angle_i (theta_i),
        .sin_o   (sin_w),
        .cos_o   (cos_w),
        .valid_o (trig_valid)
    );

    // two parallel regulators: index 0 = d axis, 1 = q axis
    logic                     pi_go;
    logic signed [W-1:0]      pi_ref  [2];
    logic signed [W-1:0]      pi_meas [2];
    logic signed [GAIN_W-1:0] pi_kp   [2];
    logic signed [GAIN_W-1:0] pi_ki   [2];
    logic signed [W-1:0]      pi_v    [2];

    assign pi_ref[0]  = r_q.idr;
    assign pi_ref[1]  = r_q.iqr;
    assign pi_meas[0] = r_q.id;
    assign pi_meas[1] = r_q.iq;
    assign pi_kp[0]   = r_q.kpd;
    assign pi_kp[1]   = r_q.kpq;
    assign pi_ki[0]   = r_q.kid;
    assign pi_ki[1]   = r_q.kiq;

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        foc_pi_axis #(.W(W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .ACC_W(ACC_W)) u_pi (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (pi_go),
            .ref_i  (pi_ref[ax]),
            .meas_i (pi_meas[ax]),
            .kp_i   (pi_kp[ax]),
            .ki_i   (pi_ki[ax]),
            .lim_i  (r_q.lim),
            .v_o    (pi_v[ax])
        );
    end

    logic signed [W+1:0]  sum3;
    logic signed [PW-1:0] prod_b, rot_d, rot_q, rot_a, rot_bv;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        trig_go = 1'b0;
        pi_go   = 1'b0;
        sum3    = $signed({{2{r_q.ia[W-1]}}, r_q.ia}) + $signed({r_q.ib[W-1], r_q.ib, 1'b0});
        prod_b  = sum3 * INV_SQRT3;
        rot_d   = $signed(r_q.alpha) * cos_w + $signed(r_q.beta) * sin_w;
        rot_q   = $signed(r_q.beta) * cos_w - $signed(r_q.alpha) * sin_w;
        rot_a   = pi_v[0] * cos_w - pi_v[1] * sin_w;
        rot_bv  = pi_v[0] * sin_w + pi_v[1] * cos_w;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    trig_go = 1'b1;
                    r_d.ia  = ia_i;
                    r_d.ib  = ib_i;
                    r_d.idr = id_ref_i;
                    r_d.iqr = iq_ref_i;
                    r_d.kpd = kp_d_i;
                    r_d.kid = ki_d_i;
                    r_d.kpq = kp_q_i;
                    r_d.kiq = ki_q_i;
                    r_d.lim = vlim_i;
                    r_d.st  = ST_CLARKE;
                end
            end
            ST_CLARKE: begin
                r_d.alpha = r_q.ia;
                r_d.beta  = sat_w(prod_b >>> (W - 1));
                r_d.st    = ST_ROTATE;
            end
            ST_ROTATE: begin
                if (trig_valid) r_d.st = ST_PARK;
            end
            ST_PARK: begin
                r_d.id = sat_w(rot_d >>> (W - 1));
                r_d.iq = sat_w(rot_q >>> (W - 1));
                r_d.st = ST_REG;
            end
            ST_REG: begin
                pi_go  = 1'b1;
                r_d.st = ST_INV;
            end
            ST_INV: begin
                r_d.va   = clamp_lim(sat_w(rot_a >>> (W - 1)), r_q.lim);
                r_d.vb   = clamp_lim(sat_w(rot_bv >>> (W - 1)), r_q.lim);
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o   = r_q.done;
    assign valpha_o = r_q.va;
    assign vbeta_o  = r_q.vb;

    // edge counter since the accepting edge, used only by the latency property
    logic [AW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           age_q <= '0;
        else if (r_q.st == ST_IDLE && start_i) age_q <= AW'(1);
        else if (r_q.st != ST_IDLE)            age_q <= age_q + 1'b1;
    end

    // R1: strobe lasts a single cycle
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: strobe arrives exactly LAT edges after the accepting edge
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (age_q == AW'(LAT + 1)));

    // R8: outputs are frozen outside the strobe cycle
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(valpha_o) && $stable(vbeta_o)));

    // R6: published voltages respect the captured limit
    p_out_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valpha_o <= r_q.lim) && (valpha_o >= -r_q.lim) &&
                   (vbeta_o <= r_q.lim) && (vbeta_o >= -r_q.lim));

endmodule

// File: tb/tb_foc_current_step.sv
`timescale 1ns/1ps
module tb_foc_current_step;
    localparam int  W   = 16;
    localparam int  GW  = 16;
    localparam int  IT  = 14;
    localparam int  LAT = IT + 4;
    localparam int  WD  = 50000;
    localparam real TOL = 40.0;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 start = 1'b0;
    logic signed [W-1:0]  ia = '0, ib = '0, idr = '0, iqr = '0, lim = '0;
    logic [W-1:0]         th = '0;
    logic signed [GW-1:0] kpd = '0, kid = '0, kpq = '0, kiq = '0;
    logic                 done;
    logic signed [W-1:0]  va, vb;

    foc_current_step #(.W(W), .GAIN_W(GW), .GAIN_FRAC(8), .ACC_W(32), .ITER(IT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .ia_i(ia), .ib_i(ib), .theta_i(th), .id_ref_i(idr), .iq_ref_i(iqr),
        .kp_d_i(kpd), .ki_d_i(kid), .kp_q_i(kpq), .ki_q_i(kiq), .vlim_i(lim),
        .done_o(done), .valpha_o(va), .vbeta_o(vb)
    );

    int    n_cmp = 0, n_bad = 0, cyc = 0, exp_cyc = -1;
    real   acc_d = 0.0, acc_q = 0.0, ev_a = 0.0, ev_b = 0.0;
    int    held_a = 0, held_b = 0;
    string cur_req = "R9";

    function automatic real clampr(input real v, input real m);
        if (v > m)  return m;
        if (v < -m) return -m;
        return v;
    endfunction

    task automatic chk_close(input int act, input real expv, input string req);
        real d;
        n_cmp++;
        d = act - expv;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_bad++;
            $display("FAIL %s: value actual %0d expected %0.1f", req, act, expv);
        end
    endtask

    task automatic chk_eq(input int act, input int expv, input string req);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // per-clock comparison against the behavioural model
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            if (cyc == exp_cyc) begin
                chk_eq(int'(done), 1, "R1");
                chk_close(int'(va), ev_a, cur_req);
                chk_close(int'(vb), ev_b, cur_req);
                held_a = int'(va);
                held_b = int'(vb);
            end else begin
                chk_eq(int'(done), 0, "R1");
                chk_eq(int'(va), held_a, "R8");
                chk_eq(int'(vb), held_b, "R8");
            end
        end
        if (cyc > WD) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic model(input int a_i, input int b_i, input int t_i, input int rd, input int rq);
        real al, be, t, c, s, idm, iqm, ed, eq, vd, vq, lm;
        lm  = lim;
        al  = a_i;
        be  = (a_i + 2.0 * b_i) / $sqrt(3.0);
        if (be > 32767.0)  be = 32767.0;
        if (be < -32768.0) be = -32768.0;
        t   = t_i * 2.0 * PI / 65536.0;
        c   = $cos(t);
        s   = $sin(t);
        idm = clampr(al * c + be * s, 32767.0);
        iqm = clampr(-al * s + be * c, 32767.0);
        ed  = rd - idm;
        eq  = rq - iqm;
        acc_d = clampr(acc_d + kid / 256.0 * ed, lm);
        acc_q = clampr(acc_q + kiq / 256.0 * eq, lm);
        vd  = clampr(kpd / 256.0 * ed + acc_d, lm);
        vq  = clampr(kpq / 256.0 * eq + acc_q, lm);
        ev_a = clampr(vd * c - vq * s, lm);
        ev_b = clampr(vd * s + vq * c, lm);
    endtask

    task automatic step(input int a_i, input int b_i, input int t_i, input int rd, input int rq,
                        input string req, input bit disturb);
        model(a_i, b_i, t_i, rd, rq);
        @(negedge clk);
        ia = W'(a_i); ib = W'(b_i); th = W'(t_i); idr = W'(rd); iqr = W'(rq);
        start = 1'b1;
        @(posedge clk);
        exp_cyc = cyc + 1 + LAT;
        cur_req = req;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10/R11: late start and input changes inside the step window
            repeat (3) @(negedge clk);
            start = 1'b1;
            ia = 16'sd20000; ib = -16'sd15000; th = 16'h5555;
            idr = 16'sd9000; iqr = -16'sd9000; kpd = 16'sd900;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc < exp_cyc + 1) @(negedge clk);
        if (disturb) kpd = 16'sd256;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk_eq(int'(done), 0, "R9");
        chk_eq(int'(va), 0, "R9");
        chk_eq(int'(vb), 0, "R9");
        kpd = 16'sd256; kid = 16'sd0; kpq = 16'sd256; kiq = 16'sd0; lim = 16'sd30000;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        step(8000, 0, 0, 0, 0, "R2", 1'b0);
        step(-5000, 9000, 0, 0, 0, "R2", 1'b0);
        step(8000, 0, 8192, 0, 0, "R3", 1'b0);
        step(-5000, 9000, 24576, 0, 0, "R3", 1'b0);
        step(-5000, 9000, -24576, 0, 0, "R3", 1'b0);
        step(-5000, 9000, -8192, 0, 0, "R7", 1'b0);
        step(6000, -2000, -32768, 0, 0, "R7", 1'b0);
        step(6000, -2000, 16384, 0, 0, "R7", 1'b0);

        kpd = 16'sd512; kpq = 16'sd128;
        step(3000, -1000, 4660, 4000, -2000, "R4", 1'b0);
        kpd = 16'sd256; kpq = 16'sd256; kid = 16'sd64; kiq = 16'sd32;
        for (int k = 0; k < 6; k++) step(2000, 1000, 2048, 6000, -3000, "R4", 1'b0);

        // R5/R6: deep saturation then recovery
        lim = 16'sd5000; kid = 16'sd1024; kiq = 16'sd1024;
        for (int k = 0; k < 4; k++) step(0, 0, 3000, 20000, -20000, "R6", 1'b0);
        step(0, 0, 3000, -1000, 1000, "R5", 1'b0);
        step(0, 0, 3000, -1000, 1000, "R5", 1'b0);

        // R12: q-axis gains off, d axis unaffected
        lim = 16'sd20000; kid = 16'sd64; kpq = 16'sd0; kiq = 16'sd0;
        step(4000, 2000, -12000, 1000, 7000, "R12", 1'b0);
        step(4000, 2000, -12000, 1000, 7000, "R12", 1'b0);

        kpq = 16'sd256; kiq = 16'sd32;
        step(7000, -3000, 10000, 2000, 1500, "R10", 1'b1);
        step(-1000, -4000, 30000, -500, 2500, "R11", 1'b1);
        step(1500, 2500, -20000, 0, 0, "R1", 1'b0);

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule